// File: doc/BRIEF.md
# Block-Merging Write Buffer

This block sits between a write-through cache and the next memory level. The processor writes single words and moves on at once. Each buffer slot holds one aligned block of sequential words with a valid bit per word. A new word whose block already sits in a slot that is not being drained is folded into that slot. Otherwise it takes a fresh slot. Slots leave oldest first, and each one goes to memory as a single block transfer with a word mask.

Processor reads look into the buffer first. A read of a word the buffer holds is answered from the buffer with the newest value. A read that finds nothing is sent to memory right away. While that read is in flight, no new drain starts, so the read completes ahead of writes that are still queued.

Two small state machines do the control work. The read side has four states. IDLE accepts a request. From IDLE, a buffer hit moves to RESP and a miss moves to FETCH. FETCH presents the memory read and moves to WAIT on acceptance. WAIT moves to RESP when the memory data arrives. RESP returns to IDLE after its one response cycle. The drain side has two states. IDLE moves to SEND when a slot is occupied and no read is using memory. SEND returns to IDLE when memory accepts the block.

Top module: `merge_write_buffer`

## Requirements
- R1: After reset the buffer is empty: `cpu_wr_ready` and `cpu_rd_ready` are 1, and `mem_wr_valid`, `mem_rd_valid` and `cpu_rd_rsp_valid` are 0.
- R2: A write whose block address (word address shifted right by 2) matches an occupied slot that is not being drained is merged into that slot. The later block transfer carries both words, and their mask bits are set. Mask bit i covers word offset i (address bits [1:0]), and that word travels in `mem_wr_data[i*32 +: 32]`.
- R3: A write to a block held in no slot takes a new slot. Slots drain strictly in allocation order.
- R4: A block transfer presents `mem_wr_block`, `mem_wr_mask` and `mem_wr_data` with `mem_wr_valid` high. These stay unchanged until `mem_wr_ready` is seen. The mask has bits only for words that were written.
- R5: Two writes to the same word before the slot drains leave only the later data in the transfer.
- R6: A read of a word held valid in the buffer is answered on the cycle after acceptance, with the buffered data and no memory read. The response pulse lasts exactly one cycle.
- R7: A read that misses the buffer issues exactly one memory read and returns its data. A drain does not start while that read is pending.
- R8: The slot being drained accepts no merges. A write to its block during the transfer takes a new slot, which drains in a later transfer.
- R9: With all 4 slots occupied, a write that matches no mergeable slot is stalled (`cpu_wr_ready` low) until a slot frees. A write that merges is still accepted.
- R10: When two slots hold the same block, a read returns the word from the younger slot.
- R11: A read of a word whose block is buffered but whose own word is not valid is sent to memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr_valid | input | 1 | Processor write request |
| cpu_wr_addr | input | 16 | Write word address |
| cpu_wr_data | input | 32 | Write data |
| cpu_wr_ready | output | 1 | Write accepted this cycle when high |
| cpu_rd_valid | input | 1 | Processor read request |
| cpu_rd_addr | input | 16 | Read word address |
| cpu_rd_ready | output | 1 | Read accepted this cycle when high |
| cpu_rd_rsp_valid | output | 1 | Read data valid pulse |
| cpu_rd_rsp_data | output | 32 | Read data |
| mem_wr_valid | output | 1 | Block transfer request |
| mem_wr_ready | input | 1 | Memory takes the block |
| mem_wr_block | output | 14 | Block address of the transfer |
| mem_wr_data | output | 128 | Block data, word i at bits i*32 |
| mem_wr_mask | output | 4 | Per-word write enables |
| mem_rd_valid | output | 1 | Memory read request |
| mem_rd_ready | input | 1 | Memory takes the read |
| mem_rd_addr | output | 16 | Memory read word address |
| mem_rd_rsp_valid | input | 1 | Memory read data valid |
| mem_rd_rsp_data | input | 32 | Memory read data |

## Verification
The bench targets the corner cases where a buffer goes wrong without any visible error. It writes the same block while its slot is mid-transfer. A design with no lock would change the data under a held transfer, or lose the late word. It reads a block stored twice, where a design that scans oldest-first returns stale data. It reads a word missing from a partly filled slot, where returning the slot's unwritten contents would be wrong. It fills all slots and then writes both a new block and a block already held, which catches a design that stalls merges or overwrites the oldest slot. It also issues a write and a read miss together and checks that the block transfer waits for the read data.

// File: rtl/wb_pkg.sv
package wb_pkg;
    typedef enum logic [1:0] {
        RD_IDLE,
        RD_FETCH,
        RD_WAIT,
        RD_RESP
    } rd_state_e;

    typedef enum logic {
        DR_IDLE,
        DR_SEND
    } dr_state_e;
endpackage

// File: rtl/wb_lookup.sv
module wb_lookup #(
    parameter int DW    = 32,
    parameter int AW    = 16,
    parameter int WORDS = 4,
    parameter int DEPTH = 4,
    localparam int OFF_W = $clog2(WORDS),
    localparam int BLK_W = AW - OFF_W,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]                      ent_used,
    input  logic [DEPTH-1:0][BLK_W-1:0]           ent_blk,
    input  logic [DEPTH-1:0][WORDS-1:0]           ent_vmask,
    input  logic [DEPTH-1:0][WORDS-1:0][DW-1:0]   ent_data,
    input  logic [PTR_W-1:0]                      head,
    input  logic                                  head_locked,
    input  logic [AW-1:0]                         wr_addr,
    input  logic [AW-1:0]                         rd_addr,
    output logic [DEPTH-1:0]                      wr_match,
    output logic                                  wr_hit,
    output logic [PTR_W-1:0]                      wr_idx,
    output logic                                  rd_hit,
    output logic [DW-1:0]                         rd_data
);
    logic [BLK_W-1:0] wr_blk, rd_blk;
    logic [OFF_W-1:0] rd_off;
    logic [PTR_W-1:0] scan;

    assign wr_blk = wr_addr[AW-1:OFF_W];
    assign rd_blk = rd_addr[AW-1:OFF_W];
    assign rd_off = rd_addr[OFF_W-1:0];

    // one comparator per slot; the slot under transfer is excluded
    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign wr_match[i] = ent_used[i] && (ent_blk[i] == wr_blk) &&
                             !(head_locked && (head == PTR_W'(i)));
    end

    assign wr_hit = |wr_match;

    always_comb begin
        wr_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (wr_match[i]) wr_idx = PTR_W'(i);
        end
    end

    // scan from oldest to youngest, so the youngest valid copy wins
    always_comb begin
        rd_hit  = 1'b0;
        rd_data = '0;
        scan    = head;
        for (int k = 0; k < DEPTH; k++) begin
            scan = head + PTR_W'(k);
            if (ent_used[scan] && (ent_blk[scan] == rd_blk) && ent_vmask[scan][rd_off]) begin
                rd_hit  = 1'b1;
                rd_data = ent_data[scan][rd_off];
            end
        end
    end
endmodule

// File: rtl/wb_read_ctl.sv
module wb_read_ctl
    import wb_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_rd_valid,
    input  logic [AW-1:0] cpu_rd_addr,
    output logic          cpu_rd_ready,
    output logic          cpu_rd_rsp_valid,
    output logic [DW-1:0] cpu_rd_rsp_data,
    input  logic          buf_hit,
    input  logic [DW-1:0] buf_data,
    output logic          mem_rd_valid,
    output logic [AW-1:0] mem_rd_addr,
    input  logic          mem_rd_ready,
    input  logic          mem_rd_rsp_valid,
    input  logic [DW-1:0] mem_rd_rsp_data,
    output logic          rd_busy
);
    rd_state_e     state, state_nx;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;

    always_comb begin
        state_nx = state;
        unique case (state)
            RD_IDLE:  if (cpu_rd_valid) state_nx = buf_hit ? RD_RESP : RD_FETCH;
            RD_FETCH: if (mem_rd_ready) state_nx = RD_WAIT;
            RD_WAIT:  if (mem_rd_rsp_valid) state_nx = RD_RESP;
            RD_RESP:  state_nx = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= RD_IDLE;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            state <= state_nx;
            if (state == RD_IDLE && cpu_rd_valid) begin
                addr_q <= cpu_rd_addr;
                if (buf_hit) data_q <= buf_data;
            end
            if (state == RD_WAIT && mem_rd_rsp_valid) data_q <= mem_rd_rsp_data;
        end
    end

    always_comb begin
        cpu_rd_ready     = (state == RD_IDLE);
        cpu_rd_rsp_valid = (state == RD_RESP);
        cpu_rd_rsp_data  = data_q;
        mem_rd_valid     = (state == RD_FETCH);
        mem_rd_addr      = addr_q;
        rd_busy          = (state == RD_FETCH) || (state == RD_WAIT) ||
                           ((state == RD_IDLE) && cpu_rd_valid && !buf_hit);
    end

    assert_rsp_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rd_rsp_valid |=> !cpu_rd_rsp_valid);

    assert_fetch_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));
endmodule

// File: rtl/wb_drain_ctl.sv
module wb_drain_ctl
    import wb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    input  logic rd_busy,
    input  logic mem_wr_ready,
    output logic sending,
    output logic done
);
    dr_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            DR_IDLE: if (pending && !rd_busy) state_nx = DR_SEND;
            DR_SEND: if (mem_wr_ready) state_nx = DR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= DR_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        sending = (state == DR_SEND);
        done    = (state == DR_SEND) && mem_wr_ready;
    end
endmodule

// File: rtl/merge_write_buffer.sv
module merge_write_buffer #(
    parameter int DW    = 32,
    parameter int AW    = 16,
    parameter int WORDS = 4,
    parameter int DEPTH = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cpu_wr_valid,
    input  logic [AW-1:0]                 cpu_wr_addr,
    input  logic [DW-1:0]                 cpu_wr_data,
    output logic                          cpu_wr_ready,
    input  logic                          cpu_rd_valid,
    input  logic [AW-1:0]                 cpu_rd_addr,
    output logic                          cpu_rd_ready,
    output logic                          cpu_rd_rsp_valid,
    output logic [DW-1:0]                 cpu_rd_rsp_data,
    output logic                          mem_wr_valid,
    input  logic                          mem_wr_ready,
    output logic [AW-$clog2(WORDS)-1:0]   mem_wr_block,
    output logic [WORDS*DW-1:0]           mem_wr_data,
    output logic [WORDS-1:0]              mem_wr_mask,
    output logic                          mem_rd_valid,
    input  logic                          mem_rd_ready,
    output logic [AW-1:0]                 mem_rd_addr,
    input  logic                          mem_rd_rsp_valid,
    input  logic [DW-1:0]                 mem_rd_rsp_data
);
    localparam int OFF_W = $clog2(WORDS);
    localparam int BLK_W = AW - OFF_W;
    localparam int PTR_W = $clog2(DEPTH);
    localparam logic [PTR_W:0] FULL_CNT = (PTR_W+1)'(DEPTH);

    logic [DEPTH-1:0]                    ent_used;
    logic [DEPTH-1:0][BLK_W-1:0]         ent_blk;
    logic [DEPTH-1:0][WORDS-1:0]         ent_vmask;
    logic [DEPTH-1:0][WORDS-1:0][DW-1:0] ent_data;
    logic [PTR_W-1:0] head, tail;
    logic [PTR_W:0]   count;

    logic [DEPTH-1:0] wr_match;
    logic             wr_hit, rd_hit, rd_busy, sending, drain_done;
    logic [PTR_W-1:0] wr_idx;
    logic [DW-1:0]    rd_buf_data;
    logic             wr_acc, alloc;
    logic [OFF_W-1:0] wr_off;

    wb_lookup #(.DW(DW), .AW(AW), .WORDS(WORDS), .DEPTH(DEPTH)) u_lookup (
        .ent_used(ent_used), .ent_blk(ent_blk), .ent_vmask(ent_vmask), .ent_data(ent_data),
        .head(head), .head_locked(sending),
        .wr_addr(cpu_wr_addr), .rd_addr(cpu_rd_addr),
        .wr_match(wr_match), .wr_hit(wr_hit), .wr_idx(wr_idx),
        .rd_hit(rd_hit), .rd_data(rd_buf_data)
    );

    wb_read_ctl #(.DW(DW), .AW(AW)) u_read (
        .clk(clk), .rst_n(rst_n),
        .cpu_rd_valid(cpu_rd_valid), .cpu_rd_addr(cpu_rd_addr), .cpu_rd_ready(cpu_rd_ready),
        .cpu_rd_rsp_valid(cpu_rd_rsp_valid), .cpu_rd_rsp_data(cpu_rd_rsp_data),
        .buf_hit(rd_hit), .buf_data(rd_buf_data),
        .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr), .mem_rd_ready(mem_rd_ready),
        .mem_rd_rsp_valid(mem_rd_rsp_valid), .mem_rd_rsp_data(mem_rd_rsp_data),
        .rd_busy(rd_busy)
    );

    wb_drain_ctl u_drain (
        .clk(clk), .rst_n(rst_n),
        .pending(count != '0), .rd_busy(rd_busy), .mem_wr_ready(mem_wr_ready),
        .sending(sending), .done(drain_done)
    );

    assign wr_off       = cpu_wr_addr[OFF_W-1:0];
    assign cpu_wr_ready = (count != FULL_CNT) || wr_hit;
    assign wr_acc       = cpu_wr_valid && cpu_wr_ready;
    assign alloc        = wr_acc && !wr_hit;

    assign mem_wr_valid = sending;
    assign mem_wr_block = ent_blk[head];
    assign mem_wr_mask  = ent_vmask[head];
    assign mem_wr_data  = ent_data[head];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent_used  <= '0;
            ent_blk   <= '0;
            ent_vmask <= '0;
            ent_data  <= '0;
            head      <= '0;
            tail      <= '0;
            count     <= '0;
        end else begin
            if (wr_acc && wr_hit) begin
                ent_data[wr_idx][wr_off]  <= cpu_wr_data;
                ent_vmask[wr_idx][wr_off] <= 1'b1;
            end
            if (alloc) begin
                ent_used[tail]          <= 1'b1;
                ent_blk[tail]           <= cpu_wr_addr[AW-1:OFF_W];
                ent_vmask[tail]         <= WORDS'(1) << wr_off;
                ent_data[tail][wr_off]  <= cpu_wr_data;
                tail                    <= tail + 1'b1;
            end
            if (drain_done) begin
                ent_used[head] <= 1'b0;
                head           <= head + 1'b1;
            end
            if (alloc && !drain_done)      count <= count + 1'b1;
            else if (!alloc && drain_done) count <= count - 1'b1;
        end
    end

    assert_single_merge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr_valid |-> $countones(wr_match) <= 1);

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid && !mem_wr_ready |=> mem_wr_valid && $stable(mem_wr_block) &&
        $stable(mem_wr_mask) && $stable(mem_wr_data));

    assert_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid |-> (mem_wr_mask != '0) && ent_used[head]);

    assert_read_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_busy |=> !$rose(mem_wr_valid));

    assert_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid && wr_hit |-> wr_idx != head);

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> !ent_used[tail]);
endmodule

// File: tb/merge_write_buffer_test.sv
module merge_write_buffer_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic         cpu_wr_valid = 1'b0;
    logic [15:0]  cpu_wr_addr = '0;
    logic [31:0]  cpu_wr_data = '0;
    logic         cpu_wr_ready;
    logic         cpu_rd_valid = 1'b0;
    logic [15:0]  cpu_rd_addr = '0;
    logic         cpu_rd_ready, cpu_rd_rsp_valid;
    logic [31:0]  cpu_rd_rsp_data;
    logic         mem_wr_valid;
    logic         mem_wr_ready = 1'b0;
    logic [13:0]  mem_wr_block;
    logic [127:0] mem_wr_data;
    logic [3:0]   mem_wr_mask;
    logic         mem_rd_valid;
    logic         mem_rd_ready = 1'b1;
    logic [15:0]  mem_rd_addr;
    logic         mem_rd_rsp_valid = 1'b0;
    logic [31:0]  mem_rd_rsp_data = '0;

    int n_checks = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    merge_write_buffer uut (
        .clk(clk), .rst_n(rst_n),
        .cpu_wr_valid(cpu_wr_valid), .cpu_wr_addr(cpu_wr_addr), .cpu_wr_data(cpu_wr_data),
        .cpu_wr_ready(cpu_wr_ready),
        .cpu_rd_valid(cpu_rd_valid), .cpu_rd_addr(cpu_rd_addr), .cpu_rd_ready(cpu_rd_ready),
        .cpu_rd_rsp_valid(cpu_rd_rsp_valid), .cpu_rd_rsp_data(cpu_rd_rsp_data),
        .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready), .mem_wr_block(mem_wr_block),
        .mem_wr_data(mem_wr_data), .mem_wr_mask(mem_wr_mask),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
        .mem_rd_rsp_valid(mem_rd_rsp_valid), .mem_rd_rsp_data(mem_rd_rsp_data)
    );

    // memory model with a drain log
    logic [31:0]  bmem [0:1023];
    logic [13:0]  lg_blk  [0:31];
    logic [3:0]   lg_mask [0:31];
    logic [127:0] lg_data [0:31];
    int lg_n = 0;
    int n_mem_reads = 0;
    int rd_cnt = 0;
    logic [15:0] rd_addr_q = '0;

    initial for (int i = 0; i < 1024; i++) bmem[i] = 32'hA500_0000 | i;

    always @(posedge clk) begin
        if (mem_wr_valid && mem_wr_ready) begin
            for (int w = 0; w < 4; w++)
                if (mem_wr_mask[w]) bmem[{mem_wr_block[7:0], w[1:0]}] = mem_wr_data[w*32 +: 32];
            if (lg_n < 32) begin
                lg_blk[lg_n]  = mem_wr_block;
                lg_mask[lg_n] = mem_wr_mask;
                lg_data[lg_n] = mem_wr_data;
            end
            lg_n = lg_n + 1;
        end
        mem_rd_rsp_valid <= 1'b0;
        if (rd_cnt == 1) begin
            mem_rd_rsp_valid <= 1'b1;
            mem_rd_rsp_data  <= bmem[rd_addr_q[9:0]];
        end
        if (rd_cnt != 0) rd_cnt = rd_cnt - 1;
        if (mem_rd_valid && mem_rd_ready) begin
            rd_addr_q   = mem_rd_addr;
            rd_cnt      = 2;
            n_mem_reads = n_mem_reads + 1;
        end
    end

    task automatic check(input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_write(input logic [15:0] a, input logic [31:0] d);
        cpu_wr_valid = 1'b1; cpu_wr_addr = a; cpu_wr_data = d;
        #1;
        while (!cpu_wr_ready) begin @(negedge clk); #1; end
        @(posedge clk);
        @(negedge clk);
        cpu_wr_valid = 1'b0;
    endtask

    task automatic do_read(input string req, input logic [15:0] a,
                           input logic [31:0] exp, input bit exp_hit);
        int lat = 1;
        int n0 = n_mem_reads;
        cpu_rd_valid = 1'b1; cpu_rd_addr = a;
        #1;
        while (!cpu_rd_ready) begin @(negedge clk); #1; end
        @(posedge clk);
        @(negedge clk);
        cpu_rd_valid = 1'b0;
        while (!cpu_rd_rsp_valid && lat < 50) begin @(negedge clk); lat++; end
        check(req, "read data", {96'd0, cpu_rd_rsp_data}, {96'd0, exp});
        if (exp_hit) begin
            check(req, "hit latency", lat, 1);
            check(req, "no memory read on hit", n_mem_reads, n0);
        end else begin
            check(req, "one memory read on miss", n_mem_reads, n0 + 1);
        end
    endtask

    task automatic wait_drains(input int n);
        int c = 0;
        while (lg_n < n && c < 500) begin @(negedge clk); c++; end
    endtask

    task automatic check_drain(input string req, input int i, input logic [13:0] blk,
                               input logic [3:0] mask, input logic [127:0] data);
        logic [127:0] m;
        for (int w = 0; w < 4; w++) m[w*32 +: 32] = {32{mask[w]}};
        check(req, "drain block", lg_blk[i], blk);
        check(req, "drain mask", lg_mask[i], mask);
        check(req, "drain data", lg_data[i] & m, data & m);
    endtask

    task automatic test_reset;
        check("R1", "wr ready", cpu_wr_ready, 1);
        check("R1", "rd ready", cpu_rd_ready, 1);
        check("R1", "mem wr valid", mem_wr_valid, 0);
        check("R1", "mem rd valid", mem_rd_valid, 0);
        check("R1", "rsp valid", cpu_rd_rsp_valid, 0);
    endtask

    // R2 R3 R5 R4 R6 R11
    task automatic test_merge_and_hits;
        int base = lg_n;
        mem_wr_ready = 1'b0;
        do_write(16'h0040, 32'h1111_0001);
        do_write(16'h0045, 32'h2222_0002);
        do_write(16'h0047, 32'h3333_0003);
        do_write(16'h0045, 32'h4444_0004);
        repeat (3) @(negedge clk);
        check("R4", "transfer held", mem_wr_valid, 1);
        check("R4", "held block", mem_wr_block, 14'h10);
        do_read("R6", 16'h0047, 32'h3333_0003, 1'b1);
        do_read("R5", 16'h0045, 32'h4444_0004, 1'b1);
        do_read("R6", 16'h0040, 32'h1111_0001, 1'b1);
        do_read("R11", 16'h0046, 32'hA500_0046, 1'b0);
        mem_wr_ready = 1'b1;
        wait_drains(base + 2);
        check_drain("R3", base, 14'h10, 4'b0001, {96'd0, 32'h1111_0001});
        check_drain("R2", base + 1, 14'h11, 4'b1010,
                    {32'h3333_0003, 32'd0, 32'h4444_0004, 32'd0});
    endtask

    // R8 R10
    task automatic test_lock_dup;
        int base = lg_n;
        mem_wr_ready = 1'b0;
        do_write(16'h0080, 32'hE000_0001);
        @(negedge clk);
        check("R8", "head in transfer", mem_wr_valid, 1);
        do_write(16'h0080, 32'hE000_0002);
        do_write(16'h0081, 32'hE000_0003);
        check("R8", "locked data unchanged", mem_wr_data[31:0], 32'hE000_0001);
        do_read("R10", 16'h0080, 32'hE000_0002, 1'b1);
        mem_wr_ready = 1'b1;
        wait_drains(base + 2);
        check_drain("R8", base, 14'h20, 4'b0001, {96'd0, 32'hE000_0001});
        check_drain("R8", base + 1, 14'h20, 4'b0011, {64'd0, 32'hE000_0003, 32'hE000_0002});
    endtask

    // R9 R3
    task automatic test_full_stall;
        int base = lg_n;
        mem_wr_ready = 1'b0;
        do_write(16'h00C0, 32'hF000_0000);
        do_write(16'h00C4, 32'hF000_0001);
        do_write(16'h00C8, 32'hF000_0002);
        do_write(16'h00CC, 32'hF000_0003);
        cpu_wr_valid = 1'b1; cpu_wr_addr = 16'h00D0; cpu_wr_data = 32'hF000_0005;
        #1;
        check("R9", "stall when full", cpu_wr_ready, 0);
        repeat (3) @(negedge clk);
        #1;
        check("R9", "still stalled", cpu_wr_ready, 0);
        cpu_wr_valid = 1'b0;
        @(negedge clk);
        cpu_wr_valid = 1'b1; cpu_wr_addr = 16'h00C9; cpu_wr_data = 32'hF000_0004;
        #1;
        check("R9", "merge accepted when full", cpu_wr_ready, 1);
        cpu_wr_valid = 1'b0;
        do_write(16'h00C9, 32'hF000_0004);
        mem_wr_ready = 1'b1;
        do_write(16'h00D0, 32'hF000_0005);
        wait_drains(base + 5);
        check_drain("R3", base,     14'h30, 4'b0001, {96'd0, 32'hF000_0000});
        check_drain("R3", base + 1, 14'h31, 4'b0001, {96'd0, 32'hF000_0001});
        check_drain("R9", base + 2, 14'h32, 4'b0011, {64'd0, 32'hF000_0004, 32'hF000_0002});
        check_drain("R3", base + 3, 14'h33, 4'b0001, {96'd0, 32'hF000_0003});
        check_drain("R9", base + 4, 14'h34, 4'b0001, {96'd0, 32'hF000_0005});
    endtask

    // R7
    task automatic test_read_priority;
        int base = lg_n;
        int n0 = n_mem_reads;
        int c = 0;
        bit early = 1'b0;
        mem_wr_ready = 1'b1;
        cpu_wr_valid = 1'b1; cpu_wr_addr = 16'h0100; cpu_wr_data = 32'h6000_0001;
        cpu_rd_valid = 1'b1; cpu_rd_addr = 16'h0108;
        #1;
        check("R7", "both accepted", {cpu_wr_ready, cpu_rd_ready}, 2'b11);
        @(posedge clk);
        @(negedge clk);
        cpu_wr_valid = 1'b0; cpu_rd_valid = 1'b0;
        while (!cpu_rd_rsp_valid && c < 50) begin
            if (mem_wr_valid) early = 1'b1;
            @(negedge clk); c++;
        end
        check("R7", "no drain before read data", early, 0);
        check("R7", "miss data", cpu_rd_rsp_data, 32'hA500_0108);
        check("R7", "one memory read", n_mem_reads, n0 + 1);
        wait_drains(base + 1);
        check_drain("R7", base, 14'h40, 4'b0001, {96'd0, 32'h6000_0001});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_merge_and_hits();
        test_lock_dup();
        test_full_stall();
        test_read_priority();
        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule